// File: doc/BRIEF.md
# Polytope Lattice Point Scanner

This block walks every integer point (i, j, k) of the solid bounded by 0 ≤ i ≤ n, 0 ≤ j ≤ n and 0 ≤ k ≤ i + j. It produces one point per handshake, in lexicographic order with i as the slowest index and k as the fastest. A three-level index controller does the stepping. The two outer levels are bounded by the loaded n. The innermost bound is not fixed: an adder recomputes it from the current i and j on every cycle. When a level reaches its bound, every level inside it is cleared and the next outer level is incremented, all in the same accepted transfer. The index registers therefore never spend idle cycles between iterations.

A single-cycle start strobe, given while the block is idle, captures n and opens the scan. Points leave on a valid/ready stream. A point is presented while `pt_valid` is high. It is held, unchanged, until a cycle in which `pt_ready` is also high. The consumer may apply back-pressure for any number of cycles, and no point is lost or repeated. The final point (n, n, 2n) is marked by `pt_last`. Once it is accepted the block goes idle and waits for the next start.

Top module: `poly_scan`

## Requirements
- R1: After reset, `pt_valid` and `busy` are low.
- R2: A `start` pulse while idle captures `n_in`. From the following cycle, `busy` and `pt_valid` are high and the presented point is (0, 0, 0).
- R3: Within one (i, j) pair, each accepted transfer with k < i + j presents the same i and j with k increased by one. At no time is k above i + j.
- R4: An accepted transfer with k = i + j and j < n presents (i, j + 1, 0) next.
- R5: An accepted transfer with k = i + j, j = n and i < n presents (i + 1, 0, 0) next.
- R6: While `pt_valid` is high and `pt_ready` is low, the presented point and `pt_valid` stay unchanged on the next cycle.
- R7: `pt_last` is high exactly when the presented point is (n, n, 2n). After that point is accepted, `pt_valid` and `busy` are low on the next cycle.
- R8: A `start` pulse while `busy` is high has no effect. The scan in progress continues with the n captured at its own start.
- R9: A scan emits exactly the sum over all i, j in 0..n of (i + j + 1) points. This holds up to the largest n that `n_in` can carry, where k reaches 2n without wrapping.
- R10: `pt_valid` equals `busy` at all times: there are no bubbles inside a scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle strobe that begins a scan when idle |
| n_in | input | IDX_W | Upper bound n, captured on an accepted start |
| busy | output | 1 | High while a scan is in progress |
| pt_valid | output | 1 | A point is presented |
| pt_ready | input | 1 | Consumer accepts the presented point |
| pt_i | output | IDX_W | Outermost index i |
| pt_j | output | IDX_W | Middle index j |
| pt_k | output | IDX_W+1 | Innermost index k |
| pt_last | output | 1 | Presented point is the final one, (n, n, 2n) |

## Verification
The hardest case to provoke is the double wrap into the last row combined with the widest k. This happens at n equal to the largest value `n_in` can carry, where k must reach 2n in a register only one bit wider than i and j. The bench sweeps several small n exhaustively under constant, alternating and pseudo-random ready patterns. It then runs the full maximum-n scan, comparing each point against an arithmetic model. It also drives a second start, with a different n, partway through a scan to show that the running bound is kept.

// File: rtl/poly_scan_pkg.sv
package poly_scan_pkg;
  localparam int unsigned NEST_LVLS = 3;
  localparam int unsigned LVL_K = 0;
  localparam int unsigned LVL_J = 1;
  localparam int unsigned LVL_I = 2;
endpackage

// File: rtl/poly_bound_add.sv
module poly_bound_add #(
  parameter int unsigned IW = 4,
  localparam int unsigned SW = IW + 1
) (
  input  logic [IW-1:0] op_a,
  input  logic [IW-1:0] op_b,
  output logic [SW-1:0] sum
);
  // widened so that 2*(2^IW - 1) fits
  assign sum = {1'b0, op_a} + {1'b0, op_b};
endmodule

// File: rtl/poly_nest_ctrl.sv
module poly_nest_ctrl #(
  parameter int unsigned NLVL = 3,
  parameter int unsigned W    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic [NLVL-1:0][W-1:0] lim,
  output logic [NLVL-1:0][W-1:0] idx,
  output logic                   all_hit
);
  // level 0 is innermost; carry[l] is high when every level inside l is at its bound
  logic [NLVL-1:0] hit;
  logic [NLVL:0]   carry;

  assign carry[0] = 1'b1;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    assign hit[l]       = (idx[l] == lim[l]);
    assign carry[l+1]   = carry[l] & hit[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx[l] <= '0;
      end else if (load) begin
        idx[l] <= '0;
      end else if (step && carry[l]) begin
        if (hit[l]) idx[l] <= '0;
        else        idx[l] <= idx[l] + 1'b1;
      end
    end
  end

  assign all_hit = carry[NLVL];
endmodule

// File: rtl/poly_scan.sv
module poly_scan #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned KW   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] n_in,
  output logic             busy,
  output logic             pt_valid,
  input  logic             pt_ready,
  output logic [IDX_W-1:0] pt_i,
  output logic [IDX_W-1:0] pt_j,
  output logic [KW-1:0]    pt_k,
  output logic             pt_last
);
  import poly_scan_pkg::*;

  logic [IDX_W-1:0]             n_lat;
  logic                         active;
  logic                         launch;
  logic                         fire;
  logic                         at_end;
  logic [KW-1:0]                k_bound;
  logic [NEST_LVLS-1:0][KW-1:0] lvl_lim;
  logic [NEST_LVLS-1:0][KW-1:0] lvl_idx;

  assign launch = start && !active;
  assign fire   = active && pt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      n_lat  <= '0;
    end else if (launch) begin
      active <= 1'b1;
      n_lat  <= n_in;
    end else if (fire && at_end) begin
      active <= 1'b0;
    end
  end

  poly_bound_add #(.IW(IDX_W)) u_bound (
    .op_a (lvl_idx[LVL_I][IDX_W-1:0]),
    .op_b (lvl_idx[LVL_J][IDX_W-1:0]),
    .sum  (k_bound)
  );

  assign lvl_lim[LVL_K] = k_bound;
  assign lvl_lim[LVL_J] = {1'b0, n_lat};
  assign lvl_lim[LVL_I] = {1'b0, n_lat};

  poly_nest_ctrl #(.NLVL(NEST_LVLS), .W(KW)) u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .step    (fire),
    .lim     (lvl_lim),
    .idx     (lvl_idx),
    .all_hit (at_end)
  );

  assign busy     = active;
  assign pt_valid = active;
  assign pt_i     = lvl_idx[LVL_I][IDX_W-1:0];
  assign pt_j     = lvl_idx[LVL_J][IDX_W-1:0];
  assign pt_k     = lvl_idx[LVL_K];
  assign pt_last  = active && at_end;
endmodule

// File: rtl/poly_scan_chk.sv
module poly_scan_chk #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned KW   = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             pt_valid,
  input logic             pt_ready,
  input logic [IDX_W-1:0] pt_i,
  input logic [IDX_W-1:0] pt_j,
  input logic [KW-1:0]    pt_k,
  input logic             pt_last,
  input logic [IDX_W-1:0] n_lat
);
  logic [KW-1:0] ij_sum;
  assign ij_sum = {1'b0, pt_i} + {1'b0, pt_j};

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> pt_valid && pt_i == '0 && pt_j == '0 && pt_k == '0); // R2

  AST_K_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> pt_k <= ij_sum); // R3

  AST_K_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && pt_ready && pt_k == ij_sum && pt_j != n_lat |=>
      pt_valid && pt_k == '0 && pt_j == IDX_W'($past(pt_j) + 1'b1) && pt_i == $past(pt_i)); // R4

  AST_J_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && pt_ready && pt_k == ij_sum && pt_j == n_lat && pt_i != n_lat |=>
      pt_valid && pt_k == '0 && pt_j == '0 && pt_i == IDX_W'($past(pt_i) + 1'b1)); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && !pt_ready |=> pt_valid && $stable(pt_i) && $stable(pt_j) && $stable(pt_k)); // R6

  AST_LAST_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    pt_last |-> pt_valid && pt_i == n_lat && pt_j == n_lat && pt_k == {n_lat, 1'b0}); // R7

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && pt_ready && pt_last |=> !pt_valid && !busy); // R7

  AST_BOUND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(n_lat)); // R8

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid == busy); // R10
endmodule

bind poly_scan poly_scan_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .pt_valid (pt_valid),
  .pt_ready (pt_ready),
  .pt_i     (pt_i),
  .pt_j     (pt_j),
  .pt_k     (pt_k),
  .pt_last  (pt_last),
  .n_lat    (n_lat)
);

// File: tb/poly_scan_bench.sv
module poly_scan_bench;
  localparam int IW = 4;
  localparam int KW = IW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] n_in = '0;
  logic          pt_ready = 1'b0;
  logic          busy, pt_valid, pt_last;
  logic [IW-1:0] pt_i, pt_j;
  logic [KW-1:0] pt_k;

  int checks = 0;
  int fails  = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  poly_scan #(.IDX_W(IW)) u_poly_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in), .busy(busy),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_i(pt_i), .pt_j(pt_j),
    .pt_k(pt_k), .pt_last(pt_last)
  );

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // mode: 0 ready always, 1 alternating, 2 pseudo-random; inject: second start mid-scan
  task automatic run_scan(input int n, input int mode, input bit inject);
    int ei = 0, ej = 0, ek = 0;
    int pts = 0, exp_pts = 0, cyc = 0;
    bit done = 0, bad = 0;
    string tag = "R2";
    for (int a = 0; a <= n; a++)
      for (int b = 0; b <= n; b++) exp_pts += a + b + 1;
    @(negedge clk);
    start = 1'b1; n_in = IW'(n); pt_ready = 1'b0;
    @(negedge clk);
    start = 1'b0; n_in = IW'((n + 3) % 16);
    while (!done) begin
      case (mode)
        0: pt_ready = 1'b1;
        1: pt_ready = cyc[0];
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          pt_ready = lfsr[0];
        end
      endcase
      start = inject && (pts == 4);
      #1;
      if (!pt_valid || !busy ||
          int'(pt_i) != ei || int'(pt_j) != ej || int'(pt_k) != ek) begin
        if (!bad)
          check(0, tag, $sformatf("n=%0d got v=%0b (%0d,%0d,%0d) exp v=1 (%0d,%0d,%0d)",
                n, pt_valid, pt_i, pt_j, pt_k, ei, ej, ek));
        bad = 1;
      end
      if (pt_last != (ei == n && ej == n && ek == 2 * n)) begin
        check(0, "R7", $sformatf("n=%0d last got %0b at (%0d,%0d,%0d)", n, pt_last, ei, ej, ek));
      end
      if (pt_ready) begin
        pts++;
        if (ek < ei + ej) begin ek++; tag = "R3"; end
        else if (ej < n) begin ej++; ek = 0; tag = "R4"; end
        else if (ei < n) begin ei++; ej = 0; ek = 0; tag = "R5"; end
        else done = 1;
      end else begin
        tag = "R6";
      end
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    pt_ready = 1'b0;
    if (!bad) check(1, "R3", "");
    check(!pt_valid && !busy, "R7",
          $sformatf("after last got v=%0b busy=%0b exp 0 0", pt_valid, busy));
    check(pts == exp_pts, "R9", $sformatf("n=%0d points got %0d exp %0d", n, pts, exp_pts));
    if (inject) check(!bad && pts == exp_pts, "R8", "start during scan disturbed it");
    check(pt_valid == busy, "R10", "valid differs from busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pt_valid && !busy, "R1", $sformatf("reset got v=%0b busy=%0b exp 0 0", pt_valid, busy));
    rst_n = 1'b1;
    @(negedge clk);
    check(!pt_valid && !busy, "R1", "idle after reset release");
    run_scan(0, 0, 0);
    run_scan(1, 1, 0);
    run_scan(2, 2, 0);
    run_scan(3, 0, 1);
    run_scan(4, 2, 1);
    run_scan(15, 0, 0);
    run_scan(5, 1, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R9", "watchdog expired");
    finish_run();
  end
endmodule